// File: doc/BRIEF.md
# Low-Power Real-Time Clock with Posted Register Writes

This block is a real-time clock split over two clocks. A fast bus clock carries a plain word-addressed register port. A slow low-power clock, nominally 32 kHz, runs the time-keeping core. The core holds a counter made of a 32-bit seconds word and a fraction field of `FRAC_W` bits (15 by default, so 47 bits in all). It also holds a seconds alarm and a run-enable bit.

Software writes reach the slow domain through a toggle handshake. While a write is travelling, a busy flag is up and a ready-for-next flag is down. When the write has landed, a done flag is raised, and reading the status word clears it. A second write issued while one is still in flight is thrown away and raises an error flag. The interrupt-mask register sits on the bus side: a write to it takes effect at once and never raises the done flag.

One level interrupt output is the OR of the status flags whose mask bits are set. The alarm is the only timed event.

Top module: `lp_rtc`

## Requirements
- R1: After reset the status word (0x14) reads 0x0000_0202: not-valid (bit 1) and ready-for-next (bit 9) are set and every other bit is 0. The mask register (0x18) reads 0, the seconds word (0x00) reads 0, and `irq` is low.
- R2: A write to 0x00, 0x04, 0x08, 0x0C, 0x10 or 0x14 is posted to the slow domain. While it is in flight, status bit 10 (busy) is 1 and bit 9 (ready) is 0. When it lands, bit 10 returns to 0, status bit 8 (done) becomes 1, and the written value can be read back.
- R3: A write to the mask register 0x18 is readable on the next bus cycle. Only bits 9, 8, 7 and 4 are kept. The write never sets status bit 8.
- R4: A bus read of the status word with `bus_rd` high clears status bit 8.
- R5: With control bit 3 set, the counter stays still until the seconds word 0x00 has been written at least once after reset.
- R6: Once started, the fraction field (0x04, low `FRAC_W` bits) increments on every slow-clock cycle while control bit 3 is 1, and its wrap carries into the seconds word. The alarm-low word 0x0C always reads 0. Control bit 3 reads back, and the other control bits read 0.
- R7: Status bit 4 (alarm) is set when the counter advances into the state where seconds equal the alarm word 0x08 and the fraction is 0.
- R8: A posted write issued while bit 10 is 1 is dropped, so the target keeps its earlier value, and status bit 7 (write error) is set.
- R9: A posted status write clears bits 7, 4 and 1 wherever its data bits are 1, at the moment it lands. Bit 0 always reads 0.
- R10: `irq` is high exactly when some status bit among 9, 8, 7 and 4 is 1 and its mask bit is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast register-bus clock |
| bus_rst_n | input | 1 | Synchronous active-low reset, bus domain |
| lp_clk | input | 1 | Slow time-keeping clock |
| lp_rst_n | input | 1 | Synchronous active-low reset, slow domain |
| bus_addr | input | ADDR_W | Byte address; bits 4:2 pick the word |
| bus_wr | input | 1 | Write strobe, one bus cycle per write |
| bus_rd | input | 1 | Read strobe; clears the done flag on a status read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the corner cases below. Each one names the failure a faulty design would show.

- **Counter not yet started.** The bench sets the run bit before the seconds word has ever been written. A design that ignores the started condition lets the counter drift away from zero.
- **Back-to-back writes.** Two writes are issued on consecutive bus cycles. A crossing that accepts while busy would store the second value and leave the error flag clear.
- **Mask-register write.** The bench checks that this write raises no done flag. A design that routes it through the handshake would set the done flag and delay the readback.
- **Alarm entry and clearing.** The counter is placed just below the alarm second and let run. A missed compare leaves the alarm flag and the interrupt low, and a broken W1C path leaves them stuck high.

// File: rtl/rtc_pkg.sv
// Shared register indices, flag positions and the posted-write record for
// the low-power RTC. Assumes a 32-bit register word.
package rtc_pkg;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 3;

    typedef enum logic [IDX_W-1:0] {
        RG_SEC   = 3'd0,
        RG_FRAC  = 3'd1,
        RG_ALM   = 3'd2,
        RG_ALM_L = 3'd3,
        RG_CTRL  = 3'd4,
        RG_STAT  = 3'd5,
        RG_MASK  = 3'd6,
        RG_NONE  = 3'd7
    } reg_idx_e;

    // Status and mask flag positions (software decodes these)
    localparam int SB_BUSY  = 10;
    localparam int SB_READY = 9;
    localparam int SB_DONE  = 8;
    localparam int SB_ERR   = 7;
    localparam int SB_ALARM = 4;
    localparam int SB_NVAL  = 1;
    localparam int CB_RUN   = 3;

    localparam logic [DATA_W-1:0] MASK_KEEP =
        (DATA_W'(1) << SB_READY) | (DATA_W'(1) << SB_DONE) |
        (DATA_W'(1) << SB_ERR)   | (DATA_W'(1) << SB_ALARM);

    typedef struct packed {
        reg_idx_e            idx;
        logic [DATA_W-1:0]   data;
    } wr_cmd_t;
endpackage

// File: rtl/rtc_sync_bit.sv
// Multi-stage single-bit synchroniser.
// Assumes: the input is a level or toggle that stays put for several
// destination cycles.
module rtc_sync_bit #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the input through the flop chain
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rtc_wr_xing.sv
// Posted-write crossing from the bus clock to the slow clock.
// - A request accepted while idle is held and announced with a request toggle.
// - The slow side applies it and answers with an acknowledge toggle.
// - A request arriving while busy is refused and reported through `drop`.
// Assumes the held command stays stable until the acknowledge returns.
module rtc_wr_xing
    import rtc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    bus_clk,
    input  logic    bus_rst_n,
    input  logic    req,
    input  wr_cmd_t req_cmd,
    output logic    busy,
    output logic    drop,
    output logic    done,
    output wr_cmd_t held_cmd,
    input  logic    lp_clk,
    input  logic    lp_rst_n,
    output logic    lp_wr,
    output wr_cmd_t lp_cmd
);
    logic req_tgl, ack_tgl;
    logic req_s, req_d;
    logic ack_s, ack_d;
    logic accept;

    assign accept = req && !busy;
    assign drop   = req && busy;
    assign done   = ack_s != ack_d;

    // Bus side: capture a request, raise busy, drop it on acknowledge
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) begin
            req_tgl  <= 1'b0;
            busy     <= 1'b0;
            held_cmd <= '0;
            ack_d    <= 1'b0;
        end else begin
            ack_d <= ack_s;
            if (accept) begin
                held_cmd <= req_cmd;
                req_tgl  <= ~req_tgl;
                busy     <= 1'b1;
            end else if (done) begin
                busy <= 1'b0;
            end
        end
    end

    rtc_sync_bit #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(bus_clk), .rst_n(bus_rst_n), .d(ack_tgl), .q(ack_s));

    rtc_sync_bit #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(lp_clk), .rst_n(lp_rst_n), .d(req_tgl), .q(req_s));

    assign lp_wr  = req_s != req_d;
    assign lp_cmd = held_cmd;

    // Slow side: detect a new request and acknowledge it on the apply edge
    always_ff @(posedge lp_clk) begin
        if (!lp_rst_n) begin
            req_d   <= 1'b0;
            ack_tgl <= 1'b0;
        end else begin
            req_d <= req_s;
            if (lp_wr) ack_tgl <= ~ack_tgl;
        end
    end
endmodule

// File: rtl/rtc_lp_core.sv
// Slow-domain time keeper.
// - Holds the seconds/fraction counter, the alarm seconds and the run bit.
// - Applies posted writes, and raises an alarm toggle when the counter
//   steps into (alarm, 0).
// - Flips a tick toggle every cycle so the bus side can mirror the state.
// Assumes: counting begins only after the seconds word has been written.
module rtc_lp_core
    import rtc_pkg::*;
#(
    parameter int FRAC_W = 15,
    parameter int SEC_W  = 32
) (
    input  logic              lp_clk,
    input  logic              lp_rst_n,
    input  logic              wr,
    input  wr_cmd_t           cmd,
    output logic [SEC_W-1:0]  sec,
    output logic [FRAC_W-1:0] frac,
    output logic [SEC_W-1:0]  alarm,
    output logic              run_en,
    output logic              tick_tgl,
    output logic              alarm_tgl
);
    logic              started;
    logic              time_wr;
    logic              advance;
    logic [FRAC_W-1:0] nxt_frac;
    logic [SEC_W-1:0]  nxt_sec;
    logic              hit;

    // Next counter value and alarm-entry detection
    always_comb begin
        time_wr  = wr && (cmd.idx == RG_SEC || cmd.idx == RG_FRAC);
        advance  = run_en && started && !time_wr;
        nxt_frac = frac + FRAC_W'(1);
        nxt_sec  = (frac == {FRAC_W{1'b1}}) ? sec + SEC_W'(1) : sec;
        hit      = advance && (nxt_frac == '0) && (nxt_sec == alarm);
    end

    // State update: writes first, then counting
    always_ff @(posedge lp_clk) begin
        if (!lp_rst_n) begin
            sec       <= '0;
            frac      <= '0;
            alarm     <= '0;
            run_en    <= 1'b0;
            started   <= 1'b0;
            tick_tgl  <= 1'b0;
            alarm_tgl <= 1'b0;
        end else begin
            tick_tgl <= ~tick_tgl;
            if (hit) alarm_tgl <= ~alarm_tgl;
            if (advance) begin
                frac <= nxt_frac;
                sec  <= nxt_sec;
            end
            if (wr) begin
                unique case (cmd.idx)
                    RG_SEC: begin
                        sec     <= cmd.data[SEC_W-1:0];
                        started <= 1'b1;
                    end
                    RG_FRAC: frac   <= cmd.data[FRAC_W-1:0];
                    RG_ALM:  alarm  <= cmd.data[SEC_W-1:0];
                    RG_CTRL: run_en <= cmd.data[CB_RUN];
                    default: ;
                endcase
            end
        end
    end

    logic unused_data;
    assign unused_data = ^cmd.data;
endmodule

// File: rtl/rtc_bus_regs.sv
// Bus-domain register file.
// - Mirrors the slow state on each tick toggle.
// - Owns the status flags and the interrupt mask, and drives read data
//   and the interrupt.
// Assumes: the slow clock period is at least four bus cycles, so the
// mirrored values are stable when they are sampled.
module rtc_bus_regs
    import rtc_pkg::*;
#(
    parameter int FRAC_W      = 15,
    parameter int SEC_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  reg_idx_e          idx,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    input  logic              done,
    input  logic              drop,
    input  wr_cmd_t           held_cmd,
    input  logic [SEC_W-1:0]  lp_sec,
    input  logic [FRAC_W-1:0] lp_frac,
    input  logic [SEC_W-1:0]  lp_alarm,
    input  logic              lp_run,
    input  logic              lp_tick,
    input  logic              lp_alarm_tgl,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              flag_done,
    output logic              flag_err,
    output logic [DATA_W-1:0] mask_q
);
    logic              tick_s, tick_d, alm_s, alm_d;
    logic              tick_edge, alm_edge;
    logic [SEC_W-1:0]  m_sec, m_alarm;
    logic [FRAC_W-1:0] m_frac;
    logic              m_run;
    logic              flag_alarm, flag_nval;
    logic              stat_clr;
    logic [DATA_W-1:0] stat_word;

    rtc_sync_bit #(.STAGES(SYNC_STAGES)) u_tick_sync (
        .clk(bus_clk), .rst_n(bus_rst_n), .d(lp_tick), .q(tick_s));
    rtc_sync_bit #(.STAGES(SYNC_STAGES)) u_alm_sync (
        .clk(bus_clk), .rst_n(bus_rst_n), .d(lp_alarm_tgl), .q(alm_s));

    assign tick_edge = tick_s != tick_d;
    assign alm_edge  = alm_s != alm_d;
    assign stat_clr  = done && (held_cmd.idx == RG_STAT);

    // Copy the slow-domain state once it has settled
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) begin
            tick_d  <= 1'b0;
            alm_d   <= 1'b0;
            m_sec   <= '0;
            m_frac  <= '0;
            m_alarm <= '0;
            m_run   <= 1'b0;
        end else begin
            tick_d <= tick_s;
            alm_d  <= alm_s;
            if (tick_edge) begin
                m_sec   <= lp_sec;
                m_frac  <= lp_frac;
                m_alarm <= lp_alarm;
                m_run   <= lp_run;
            end
        end
    end

    // Status flags: a set wins over a clear in the same cycle
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) begin
            flag_done  <= 1'b0;
            flag_err   <= 1'b0;
            flag_alarm <= 1'b0;
            flag_nval  <= 1'b1;
        end else begin
            if (done)                                       flag_done <= 1'b1;
            else if (rd && idx == RG_STAT)                  flag_done <= 1'b0;
            if (drop)                                       flag_err <= 1'b1;
            else if (stat_clr && held_cmd.data[SB_ERR])     flag_err <= 1'b0;
            if (alm_edge)                                   flag_alarm <= 1'b1;
            else if (stat_clr && held_cmd.data[SB_ALARM])   flag_alarm <= 1'b0;
            if (stat_clr && held_cmd.data[SB_NVAL])         flag_nval <= 1'b0;
        end
    end

    // Interrupt mask: written at bus speed
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n)                mask_q <= '0;
        else if (wr && idx == RG_MASK) mask_q <= wdata & MASK_KEEP;
    end

    // Assemble the status word
    always_comb begin
        stat_word           = '0;
        stat_word[SB_BUSY]  = busy;
        stat_word[SB_READY] = !busy;
        stat_word[SB_DONE]  = flag_done;
        stat_word[SB_ERR]   = flag_err;
        stat_word[SB_ALARM] = flag_alarm;
        stat_word[SB_NVAL]  = flag_nval;
    end

    // Read multiplexer
    always_comb begin
        rdata = '0;
        unique case (idx)
            RG_SEC:  rdata = DATA_W'(m_sec);
            RG_FRAC: rdata = DATA_W'(m_frac);
            RG_ALM:  rdata = DATA_W'(m_alarm);
            RG_CTRL: rdata[CB_RUN] = m_run;
            RG_STAT: rdata = stat_word;
            RG_MASK: rdata = mask_q;
            default: rdata = '0;
        endcase
    end

    assign irq = |(mask_q & stat_word);
endmodule

// File: rtl/lp_rtc.sv
// Top of the low-power RTC.
// - Decodes the bus address.
// - Sends posted writes through the crossing and hosts the slow core
//   and the bus register file.
// Assumes: word-aligned accesses; address bits above 4 must be zero for a hit.
module lp_rtc
    import rtc_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int FRAC_W      = 15,
    parameter int SEC_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              lp_clk,
    input  logic              lp_rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    localparam int IDX_LO = 2;
    localparam int IDX_HI = IDX_LO + IDX_W - 1;

    logic              upper_ok;
    reg_idx_e          reg_idx;
    logic              post_req;
    wr_cmd_t           post_cmd, held_cmd, lp_cmd;
    logic              st_busy, wr_drop, wr_done, lp_wr;
    logic              st_wcf, st_wef;
    logic [31:0]       ier_q;
    logic [SEC_W-1:0]  c_sec, c_alarm;
    logic [FRAC_W-1:0] c_frac;
    logic              c_run, c_tick, c_alarm_tgl;

    // Upper address bits exist only when the bus is wider than the map
    generate
        if (ADDR_W > IDX_HI + 1) begin : g_wide
            assign upper_ok = ~|bus_addr[ADDR_W-1:IDX_HI+1];
        end else begin : g_narrow
            assign upper_ok = 1'b1;
        end
    endgenerate

    assign reg_idx  = upper_ok ? reg_idx_e'(bus_addr[IDX_HI:IDX_LO]) : RG_NONE;
    assign post_req = bus_wr && (reg_idx <= RG_STAT);
    assign post_cmd = '{idx: reg_idx, data: bus_wdata};

    rtc_wr_xing #(.SYNC_STAGES(SYNC_STAGES)) u_xing (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
        .req(post_req), .req_cmd(post_cmd),
        .busy(st_busy), .drop(wr_drop), .done(wr_done), .held_cmd(held_cmd),
        .lp_clk(lp_clk), .lp_rst_n(lp_rst_n),
        .lp_wr(lp_wr), .lp_cmd(lp_cmd));

    rtc_lp_core #(.FRAC_W(FRAC_W), .SEC_W(SEC_W)) u_core (
        .lp_clk(lp_clk), .lp_rst_n(lp_rst_n),
        .wr(lp_wr), .cmd(lp_cmd),
        .sec(c_sec), .frac(c_frac), .alarm(c_alarm), .run_en(c_run),
        .tick_tgl(c_tick), .alarm_tgl(c_alarm_tgl));

    rtc_bus_regs #(.FRAC_W(FRAC_W), .SEC_W(SEC_W), .SYNC_STAGES(SYNC_STAGES)) u_regs (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
        .idx(reg_idx), .wr(bus_wr), .rd(bus_rd), .wdata(bus_wdata),
        .busy(st_busy), .done(wr_done), .drop(wr_drop), .held_cmd(held_cmd),
        .lp_sec(c_sec), .lp_frac(c_frac), .lp_alarm(c_alarm), .lp_run(c_run),
        .lp_tick(c_tick), .lp_alarm_tgl(c_alarm_tgl),
        .rdata(bus_rdata), .irq(irq),
        .flag_done(st_wcf), .flag_err(st_wef), .mask_q(ier_q));

    logic unused_addr;
    assign unused_addr = ^bus_addr[IDX_LO-1:0];
endmodule

// File: rtl/lp_rtc_chk.sv
// Bus-side protocol checks for lp_rtc, attached with bind.
// Assumes: it sees the decoded index and the internal flag and handshake nets.
module lp_rtc_chk (
    input logic        bus_clk,
    input logic        bus_rst_n,
    input logic        wr,
    input logic        rd,
    input logic [2:0]  idx,
    input logic        busy,
    input logic        done,
    input logic        wcf,
    input logic        wef,
    input logic [31:0] ier,
    input logic        irq
);
    p_accept_busy_r2: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (wr && idx <= 3'd5 && !busy) |=> busy);

    p_land_sets_done_r2: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        done |=> wcf);

    p_mask_write_quiet_r3: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (wr && idx == 3'd6 && !done && !wcf) |=> !wcf);

    p_status_read_clears_r4: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (rd && idx == 3'd5 && !done) |=> !wcf);

    p_busy_write_errors_r8: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (wr && idx <= 3'd5 && busy) |=> wef);

    p_masked_off_quiet_r10: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (ier == 32'd0) |-> !irq);
endmodule

bind lp_rtc lp_rtc_chk u_chk (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
    .wr(bus_wr), .rd(bus_rd), .idx(reg_idx),
    .busy(st_busy), .done(wr_done), .wcf(st_wcf), .wef(st_wef),
    .ier(ier_q), .irq(irq));

// File: tb/sim_lp_rtc.sv
module sim_lp_rtc;
    localparam int BUS_PER = 10;
    localparam int LP_HALF = 35;
    localparam int LP_PER  = 2 * LP_HALF;
    localparam int FW      = 4;
    localparam int NVEC    = 6;

    // Table: word index, write data, expected readback
    localparam logic [2:0]  V_IDX [NVEC] = '{3'd2, 3'd3, 3'd1, 3'd0, 3'd6, 3'd4};
    localparam logic [31:0] V_WD  [NVEC] = '{32'h1234_5678, 32'h0000_FFFF, 32'h0000_0039,
                                             32'h0000_00A5, 32'hFFFF_FFFF, 32'hFFFF_FFF7};
    localparam logic [31:0] V_EXP [NVEC] = '{32'h1234_5678, 32'h0, 32'h9,
                                             32'hA5, 32'h0000_0390, 32'h0};

    logic        bus_clk = 0, lp_clk = 0;
    logic        bus_rst_n = 0, lp_rst_n = 0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          compared = 0, mismatched = 0;

    always #(BUS_PER/2) bus_clk = ~bus_clk;
    initial begin
        #3;
        forever #(LP_HALF) lp_clk = ~lp_clk;
    end

    lp_rtc #(.ADDR_W(5), .FRAC_W(FW)) u0 (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .lp_clk(lp_clk), .lp_rst_n(lp_rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic peek(input logic [2:0] idx, output logic [31:0] d);
        @(negedge bus_clk);
        bus_addr = {idx, 2'b00};
        #1 d = bus_rdata;
    endtask

    task automatic read_clr(input logic [2:0] idx, output logic [31:0] d);
        @(negedge bus_clk);
        bus_addr = {idx, 2'b00};
        bus_rd = 1;
        #1 d = bus_rdata;
        @(negedge bus_clk);
        bus_rd = 0;
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        @(negedge bus_clk);
        bus_addr = {idx, 2'b00};
        bus_wdata = d;
        bus_wr = 1;
        @(negedge bus_clk);
        bus_wr = 0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 200; i++) begin
            peek(3'd5, s);
            if (!s[10]) break;
        end
    endtask

    task automatic wr_wait(input logic [2:0] idx, input logic [31:0] d);
        wr(idx, d);
        wait_idle();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        #(BUS_PER * 150000);
        compared++;
        mismatched++;
        $display("FAIL watchdog (all requirements) actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d, hi, lo;
        int total;
        repeat (8) @(negedge bus_clk);
        bus_rst_n = 1;
        lp_rst_n = 1;
        repeat (2) @(negedge bus_clk);

        // R1 reset state
        peek(3'd5, d); chk("R1 status after reset", d, 32'h0000_0202);
        peek(3'd6, d); chk("R1 mask after reset", d, 32'h0);
        peek(3'd0, d); chk("R1 seconds after reset", d, 32'h0);
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);

        // R5 run bit set but seconds never written
        wr_wait(3'd4, 32'h8);
        peek(3'd4, d); chk("R6 control run bit readback", d, 32'h8);
        #(10 * LP_PER);
        peek(3'd1, d); chk("R5 fraction still before start", d, 32'h0);
        peek(3'd0, d); chk("R5 seconds still before start", d, 32'h0);
        wr_wait(3'd4, 32'h0);

        // R9 clear not-valid flag
        wr_wait(3'd5, 32'h2);
        peek(3'd5, d); chk("R9 not-valid cleared, bit0 zero", d & 32'h3, 32'h0);

        // Table of writes and readbacks (R2, R3, R4, R6)
        for (int v = 0; v < NVEC; v++) begin
            read_clr(3'd5, d);
            wr(V_IDX[v], V_WD[v]);
            if (V_IDX[v] == 3'd6) begin
                peek(3'd6, d); chk("R3 mask readback next cycle", d, V_EXP[v]);
                peek(3'd5, d); chk("R3 mask write sets no done", d & 32'h500, 32'h0);
                wr(3'd6, 32'h0);
            end else begin
                wait_idle();
                peek(V_IDX[v], d); chk("R2 posted readback", d, V_EXP[v]);
                peek(3'd5, d); chk("R2 done set on landing", d & 32'h700, 32'h300);
                read_clr(3'd5, d);
                peek(3'd5, d); chk("R4 done cleared by read", d & 32'h100, 32'h0);
            end
        end

        // R6 counting with carry
        wr_wait(3'd1, 32'h0);
        wr_wait(3'd0, 32'd10);
        wr_wait(3'd4, 32'h8);
        #(20 * LP_PER);
        wr_wait(3'd4, 32'h0);
        peek(3'd0, hi);
        peek(3'd1, lo);
        total = int'(hi) * 16 + int'(lo) - 160;
        chk("R6 ticks counted with carry", {31'd0, (total >= 19 && total <= 26)}, 32'd1);

        // R7 alarm entry, R10 irq, R9 clear
        wr_wait(3'd1, 32'd12);
        wr_wait(3'd0, 32'd20);
        wr_wait(3'd2, 32'd21);
        wr(3'd6, 32'h10);
        peek(3'd5, d); chk("R7 alarm clear before run", d & 32'h10, 32'h0);
        chk("R10 irq low before alarm", {31'd0, irq}, 32'd0);
        wr_wait(3'd4, 32'h8);
        #(10 * LP_PER);
        peek(3'd5, d); chk("R7 alarm flag set", d & 32'h10, 32'h10);
        chk("R10 irq high on masked-in alarm", {31'd0, irq}, 32'd1);
        wr_wait(3'd5, 32'h10);
        peek(3'd5, d); chk("R9 alarm flag cleared", d & 32'h10, 32'h0);
        chk("R10 irq drops after clear", {31'd0, irq}, 32'd0);
        wr_wait(3'd4, 32'h0);
        wr(3'd6, 32'h0);

        // R8 back-to-back writes
        read_clr(3'd5, d);
        wr(3'd6, 32'h80);
        @(negedge bus_clk);
        bus_addr = 5'h08; bus_wdata = 32'h55; bus_wr = 1;
        @(negedge bus_clk);
        bus_wdata = 32'h66;
        @(negedge bus_clk);
        bus_wr = 0;
        peek(3'd5, d); chk("R2 busy up, ready down, R8 error", d & 32'h680, 32'h480);
        chk("R10 irq on masked-in error", {31'd0, irq}, 32'd1);
        wait_idle();
        peek(3'd2, d); chk("R8 dropped write left no trace", d, 32'h55);
        wr_wait(3'd5, 32'h80);
        peek(3'd5, d); chk("R9 error flag cleared", d & 32'h80, 32'h0);
        chk("R10 irq low after error clear", {31'd0, irq}, 32'd0);
        wr(3'd6, 32'h0);

        summary();
        $finish;
    end
endmodule